// File: doc/BRIEF.md
# One-Time-Programmable Memory Burn Sequencer

This controller writes a block of words into a one-time-programmable memory, starting at address zero. It reads each intended word from a source port that is indexed by address. It drives the memory's address, write data, chip-enable, output-enable and program strobe. It also raises two request lines that an external regulator turns into the programming-level core and programming supplies. The controller works in three phases.

- **Blind pass.** Each word receives one program pulse, and nothing is read back.
- **Verify pass.** Each word is read back and compared with the intended data. A word that does not match receives further pulses, with a read-back after each one, up to a bounded number.
- **Final compare.** Both supply requests drop to nominal, and the whole block is read and compared once more.

The run ends with a pass or fail result and, on failure, the failing address.

Every timing is expressed in microseconds or nanoseconds and converted to clock cycles through the `TICKS_PER_US` parameter.

The source port is a combinational lookup: `src_addr` always equals the current device address, and `src_data` must return the word for that address in the same cycle. The source port has no handshake and no back-pressure. The sequencer holds `src_addr` for as long as it needs the word.

The device data bus is split into `dev_dq_out`, `dev_dq_oe` and `dev_dq_in`, so the pad can be built outside the block.

Top module: `otp_burn_seq`

## Requirements
- R1: In reset and while idle, the outputs are held at rest:
  - `busy`, `done` and `pass` are 0.
  - `dev_ce_n`, `dev_oe_n` and `dev_pgm_n` are 1.
  - `dev_dq_oe` is 0.
  - `vcc_hi` and `vpp_hi` are 0.
- R2: A `start` pulse while idle has these effects one cycle later:
  - `busy` is 1.
  - `done` and `pass` are cleared.
  - `vcc_hi` and `vpp_hi` are 1 (1 = programming level, 0 = nominal).
- R3: Every low period of `dev_pgm_n` lasts exactly `PULSE_US*TICKS_PER_US` cycles. This is 100 µs by default.
- R4: While `dev_pgm_n` is low, these hold, and `dev_addr` and `dev_dq_out` do not change:
  - `dev_ce_n` is 0 and `dev_oe_n` is 1.
  - `dev_dq_oe` is 1.
  - `vcc_hi` and `vpp_hi` are both 1.
- R5: The pulse is set up and held as follows:
  - Address, data drive, chip-enable, the output-enable high level and the raised supplies are steady for at least `SETUP_US` (2 µs) before `dev_pgm_n` falls.
  - `dev_dq_oe` stays 1 with unchanged data for `HOLD_US` (2 µs) after `dev_pgm_n` rises.
- R6: The blind pass issues exactly one pulse per word, at addresses 0, 1, …, `NUM_WORDS-1` in that order. `dev_oe_n` stays 1 throughout this pass.
- R7: The verify pass reads each word with `dev_oe_n`=0 and `dev_pgm_n`=1. On a mismatch it applies another pulse to the same address and reads again, for at most `MAX_RETRY` (10) extra pulses per word. The retry count restarts at each new word.
- R8: If a word still mismatches after `MAX_RETRY` extra pulses, the run ends at once with these results, and no further pulse follows:
  - `done`=1, `pass`=0 and `busy`=0.
  - `fail_addr` holds that address.
  - Both supply requests are at 0.
- R9: After every word verifies, both supply requests drop to 0 for `SETUP_US` before the final compare. The final compare then reads each word at nominal supply, in rising address order. The first mismatch ends the run with `pass`=0 and `fail_addr` set to that address. If there is no mismatch, the run ends with `pass`=1.
- R10: `dev_dq_oe` is 0 in every cycle in which `dev_oe_n` is 0. A read-back is sampled no earlier than the second cycle after output-enable falls or the address changes, and at least `FLOAT_NS + ACCESS_NS` after the bus is released.
- R11: `start` has no effect while `busy` is 1. `done`, `pass` and `fail_addr` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burn run (accepted only while idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished; result valid |
| pass | output | 1 | Result of last run: 1 = all words correct |
| fail_addr | output | ADDR_W | Address that failed (valid when done and not pass) |
| src_addr | output | ADDR_W | Address of the wanted source word |
| src_data | input | DATA_W | Intended word for src_addr, same cycle |
| dev_addr | output | ADDR_W | Memory address |
| dev_dq_out | output | DATA_W | Data to program |
| dev_dq_oe | output | 1 | Drive enable for dev_dq_out onto the memory bus |
| dev_dq_in | input | DATA_W | Data read from the memory bus |
| dev_ce_n | output | 1 | Chip enable, active low |
| dev_oe_n | output | 1 | Output enable, active low |
| dev_pgm_n | output | 1 | Program strobe, active low |
| vcc_hi | output | 1 | Request core supply at programming level |
| vpp_hi | output | 1 | Request programming supply at programming level |

## Verification
The assertions check on every cycle the rules that hold regardless of the memory's behaviour:
- the exact pulse width;
- the control levels and frozen address and data during a pulse;
- the absence of any read during the blind pass;
- that the bus is never driven while output-enable is low;
- the retry bound;
- nominal supplies whenever idle.

The bench scenarios cover what depends on how the modelled memory responds:
- words that need several pulses;
- a word that needs exactly the retry limit and one that needs one pulse more;
- a word that flips after the supplies drop, caught only by the final compare;
- the pulse order of the blind pass;
- a read-back that would be sampled too early;
- `start` arriving mid-run.

// File: rtl/otp_burn_pkg.sv
package otp_burn_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RAISE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_VERIFY,
    ST_LOWER,
    ST_CHECK
  } burn_state_e;

  // nanoseconds to cycles, rounded up, never below one cycle
  function automatic int ns_to_cyc(input int ns, input int ticks_per_us);
    int c;
    c = (ns * ticks_per_us + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/otp_phase_timer.sv
module otp_phase_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         expired
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count <= '0;
    else if (load)        count <= load_val;
    else if (count != '0) count <= count - 1'b1;
  end

  assign expired = (count == '0);

endmodule

// File: rtl/otp_retry_ctr.sv
module otp_retry_ctr #(
  parameter int MAX_RETRY = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic sat
);

  localparam int CW = $clog2(MAX_RETRY + 1) + 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (inc && !sat) cnt <= cnt + 1'b1;
  end

  assign sat = (cnt == CW'(MAX_RETRY));

  // R7
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_RETRY));

endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
  import otp_burn_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int NUM_WORDS    = 1 << ADDR_W,
  parameter int TICKS_PER_US = 125,
  parameter int PULSE_US     = 100,
  parameter int SETUP_US     = 2,
  parameter int HOLD_US      = 2,
  parameter int FLOAT_NS     = 130,
  parameter int ACCESS_NS    = 70,
  parameter int MAX_RETRY    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_dq_out,
  output logic              dev_dq_oe,
  input  logic [DATA_W-1:0] dev_dq_in,
  output logic              dev_ce_n,
  output logic              dev_oe_n,
  output logic              dev_pgm_n,
  output logic              vcc_hi,
  output logic              vpp_hi
);

  localparam int PULSE_CYC = PULSE_US * TICKS_PER_US;
  localparam int SETUP_CYC = SETUP_US * TICKS_PER_US;
  localparam int HOLD_CYC  = HOLD_US * TICKS_PER_US;
  localparam int FLOAT_CYC = ns_to_cyc(FLOAT_NS, TICKS_PER_US);
  localparam int ACC_CYC   = ns_to_cyc(ACCESS_NS, TICKS_PER_US);
  localparam int VER_CYC   = FLOAT_CYC + ACC_CYC;
  localparam int PREP_CYC  = FLOAT_CYC + SETUP_CYC;
  localparam int TW        = $clog2(PULSE_CYC + PREP_CYC + HOLD_CYC + VER_CYC + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS - 1);

  burn_state_e       state, nxt;
  logic [ADDR_W-1:0] addr;
  logic              verify_ph;
  logic              t_load, t_exp;
  logic [TW-1:0]     t_val, t_cnt;
  logic              r_clr, r_inc, r_sat;
  logic              addr_clr, addr_inc, ph_set, fin, fin_ok, accept;
  logic              match, last;

  otp_phase_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
    .count(t_cnt), .expired(t_exp)
  );

  otp_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk(clk), .rst_n(rst_n), .clr(r_clr), .inc(r_inc), .sat(r_sat)
  );

  assign match  = (dev_dq_in == src_data);
  assign last   = (addr == LAST_ADDR);
  assign accept = (state == ST_IDLE) && start;

  always_comb begin
    nxt = state; t_load = 1'b0; t_val = '0;
    addr_clr = 1'b0; addr_inc = 1'b0; ph_set = 1'b0;
    r_clr = 1'b0; r_inc = 1'b0; fin = 1'b0; fin_ok = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        nxt = ST_RAISE; t_load = 1'b1; t_val = TW'(SETUP_CYC - 1);
        addr_clr = 1'b1; r_clr = 1'b1;
      end
      ST_RAISE: if (t_exp) begin
        nxt = ST_SETUP; t_load = 1'b1; t_val = TW'(PREP_CYC - 1);
      end
      ST_SETUP: if (t_exp) begin
        nxt = ST_PULSE; t_load = 1'b1; t_val = TW'(PULSE_CYC - 1);
      end
      ST_PULSE: if (t_exp) begin
        nxt = ST_HOLD; t_load = 1'b1; t_val = TW'(HOLD_CYC - 1);
      end
      ST_HOLD: if (t_exp) begin
        t_load = 1'b1;
        if (verify_ph || last) begin
          nxt = ST_VERIFY; t_val = TW'(VER_CYC - 1);
          if (!verify_ph) begin addr_clr = 1'b1; ph_set = 1'b1; end
        end else begin
          nxt = ST_SETUP; t_val = TW'(PREP_CYC - 1); addr_inc = 1'b1;
        end
      end
      ST_VERIFY: if (t_exp) begin
        if (match) begin
          r_clr = 1'b1; t_load = 1'b1;
          if (last) begin
            nxt = ST_LOWER; t_val = TW'(SETUP_CYC - 1); addr_clr = 1'b1;
          end else begin
            t_val = TW'(VER_CYC - 1); addr_inc = 1'b1;
          end
        end else if (r_sat) begin
          nxt = ST_IDLE; fin = 1'b1;
        end else begin
          nxt = ST_SETUP; t_load = 1'b1; t_val = TW'(PREP_CYC - 1); r_inc = 1'b1;
        end
      end
      ST_LOWER: if (t_exp) begin
        nxt = ST_CHECK; t_load = 1'b1; t_val = TW'(VER_CYC - 1);
      end
      ST_CHECK: if (t_exp) begin
        if (!match || last) begin
          nxt = ST_IDLE; fin = 1'b1; fin_ok = match;
        end else begin
          t_load = 1'b1; t_val = TW'(VER_CYC - 1); addr_inc = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; addr <= '0; verify_ph <= 1'b0;
      busy <= 1'b0; done <= 1'b0; pass <= 1'b0; fail_addr <= '0;
    end else begin
      state <= nxt;
      if (addr_clr)      addr <= '0;
      else if (addr_inc) addr <= addr + 1'b1;
      if (accept)      verify_ph <= 1'b0;
      else if (ph_set) verify_ph <= 1'b1;
      if (accept) begin
        busy <= 1'b1; done <= 1'b0; pass <= 1'b0; fail_addr <= '0;
      end else if (fin) begin
        busy <= 1'b0; done <= 1'b1; pass <= fin_ok;
        if (!fin_ok) fail_addr <= addr;
      end
    end
  end

  // outputs decoded from the registered state
  assign dev_addr   = addr;
  assign src_addr   = addr;
  assign dev_dq_out = src_data;
  assign dev_pgm_n  = (state != ST_PULSE);
  assign dev_oe_n   = !(state == ST_VERIFY || state == ST_CHECK);
  assign dev_ce_n   = (state == ST_IDLE || state == ST_RAISE || state == ST_LOWER);
  assign dev_dq_oe  = (state == ST_PULSE) || (state == ST_HOLD) ||
                      (state == ST_SETUP && t_cnt < TW'(SETUP_CYC));
  assign vcc_hi     = (state == ST_RAISE) || (state == ST_SETUP) || (state == ST_PULSE) ||
                      (state == ST_HOLD)  || (state == ST_VERIFY);
  assign vpp_hi     = vcc_hi;

  // pulse-width observer for the checks below
  logic [TW-1:0] pw_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pw_seen <= '0;
    else if (!dev_pgm_n) pw_seen <= pw_seen + 1'b1;
    else                 pw_seen <= '0;
  end

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_pgm_n) |-> (pw_seen == TW'(PULSE_CYC)));

  // R4
  pulse_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_pgm_n |-> (!dev_ce_n && dev_oe_n && dev_dq_oe && vcc_hi && vpp_hi));

  // R4
  pulse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_pgm_n && $past(!dev_pgm_n)) |-> ($stable(dev_addr) && $stable(dev_dq_out)));

  // R10
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_oe_n |-> !dev_dq_oe);

  // R6
  blind_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !verify_ph) |-> dev_oe_n);

  // R8
  idle_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!vcc_hi && !vpp_hi && dev_pgm_n && dev_ce_n));

endmodule

// File: tb/tb_otp_burn_seq.sv
module tb_otp_burn_seq;

  localparam int AW = 3;
  localparam int DW = 16;
  localparam int NW = 8;
  localparam int TPU = 2;
  localparam int PULSE = 100 * TPU;
  localparam int SETUP = 2 * TPU;
  localparam int HOLD = 2 * TPU;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic busy, done, pass;
  logic [AW-1:0] fail_addr, src_addr, dev_addr;
  logic [DW-1:0] src_data, dev_dq_out, dev_dq_in;
  logic dev_dq_oe, dev_ce_n, dev_oe_n, dev_pgm_n, vcc_hi, vpp_hi;

  otp_burn_seq #(.ADDR_W(AW), .DATA_W(DW), .NUM_WORDS(NW), .TICKS_PER_US(TPU)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .pass(pass),
    .fail_addr(fail_addr), .src_addr(src_addr), .src_data(src_data),
    .dev_addr(dev_addr), .dev_dq_out(dev_dq_out), .dev_dq_oe(dev_dq_oe),
    .dev_dq_in(dev_dq_in), .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n),
    .dev_pgm_n(dev_pgm_n), .vcc_hi(vcc_hi), .vpp_hi(vpp_hi)
  );

  function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a);
    return 16'hC35A ^ ({13'h0, a} * 16'h0111);
  endfunction
  assign src_data = pattern(src_addr);

  // scenario: slow word, pulses it needs, corruption, expected results
  typedef struct packed {
    logic [7:0]  slow;
    logic [7:0]  need;
    logic        cor_en;
    logic [7:0]  cor_addr;
    logic        exp_pass;
    logic [7:0]  exp_fail;
    logic [15:0] exp_pulses;
    logic [15:0] exp_fin_cyc;
  } case_t;

  localparam int NCASE = 6;
  localparam case_t CASES [NCASE] = '{
    '{8'd0, 8'd1,  1'b0, 8'd0, 1'b1, 8'd0, 16'd8,  16'd16},
    '{8'd3, 8'd4,  1'b0, 8'd0, 1'b1, 8'd0, 16'd11, 16'd16},
    '{8'd5, 8'd11, 1'b0, 8'd0, 1'b1, 8'd0, 16'd18, 16'd16},
    '{8'd2, 8'd12, 1'b0, 8'd0, 1'b0, 8'd2, 16'd18, 16'd0},
    '{8'd0, 8'd1,  1'b1, 8'd6, 1'b0, 8'd6, 16'd8,  16'd14},
    '{8'd7, 8'd2,  1'b1, 8'd0, 1'b0, 8'd0, 16'd9,  16'd2}
  };

  // memory model
  logic [DW-1:0] mem [NW];
  int pulses_at [NW];
  int total_pulses, rd_cnt, order_err;
  logic [AW-1:0] prev_addr;
  logic prev_pgm = 1'b1, prev_vcc = 1'b0;
  int cur_slow, cur_need, cur_cor_addr;
  logic cur_cor_en;

  function automatic int need_of(input logic [AW-1:0] a);
    return (int'(a) == cur_slow) ? cur_need : 1;
  endfunction

  assign dev_dq_in = (!dev_oe_n && !dev_ce_n && rd_cnt >= 1) ? mem[dev_addr] : ~mem[dev_addr];

  always @(posedge clk) begin
    if (!dev_oe_n) rd_cnt <= (dev_addr == prev_addr) ? rd_cnt + 1 : 1;
    else rd_cnt <= 0;
    prev_addr <= dev_addr;
    prev_pgm <= dev_pgm_n;
    prev_vcc <= vcc_hi;
    if (dev_pgm_n && !prev_pgm) begin
      if (total_pulses < NW && int'(dev_addr) != total_pulses) order_err <= order_err + 1;
      pulses_at[dev_addr] <= pulses_at[dev_addr] + 1;
      total_pulses <= total_pulses + 1;
      if (pulses_at[dev_addr] + 1 >= need_of(dev_addr)) mem[dev_addr] <= dev_dq_out;
    end
    if (prev_vcc && !vcc_hi && cur_cor_en)
      mem[cur_cor_addr[AW-1:0]] <= mem[cur_cor_addr[AW-1:0]] ^ 16'h0010;
  end

  // port monitors
  int m3, m4, m5, m6, m10, fin_cyc, low_w, since, hcnt;
  logic was_low = 1'b0;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_data;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dev_pgm_n) low_w++;
      else begin
        if (low_w != 0 && low_w != PULSE) m3++;
        low_w = 0;
      end
      if (!dev_pgm_n) begin
        if (dev_ce_n || !dev_oe_n || !dev_dq_oe || !vcc_hi || !vpp_hi) m4++;
        if (was_low && (dev_addr != l_addr || dev_dq_out != l_data)) m4++;
        if (!was_low && since < SETUP) m5++;
      end
      if (was_low && dev_pgm_n) hcnt = 1;
      else if (hcnt > 0 && hcnt < HOLD) hcnt++;
      else hcnt = 0;
      if (hcnt > 0 && (!dev_dq_oe || dev_dq_out != l_data)) m5++;
      if (!(dev_dq_oe && !dev_ce_n && dev_oe_n && vcc_hi && vpp_hi)) since = 0;
      else if (dev_addr != l_addr || dev_dq_out != l_data) since = 1;
      else since++;
      if (!dev_oe_n && total_pulses < NW) m6++;
      if (!dev_oe_n && dev_dq_oe) m10++;
      if (!dev_oe_n && !vcc_hi && !vpp_hi) fin_cyc++;
    end
    was_low = !dev_pgm_n;
    l_addr = dev_addr;
    l_data = dev_dq_out;
  end

  int total = 0, bad = 0;
  logic finished = 1'b0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rest(input string tag);
    chk(!busy && !done && !pass, {tag, " status"}, {busy, done, pass}, 0);
    chk(dev_ce_n && dev_oe_n && dev_pgm_n && !dev_dq_oe, {tag, " controls"},
        {dev_ce_n, dev_oe_n, dev_pgm_n, dev_dq_oe}, 4'b1110);
    chk(!vcc_hi && !vpp_hi, {tag, " supplies"}, {vcc_hi, vpp_hi}, 0);
  endtask

  task automatic run_case(input case_t c);
    int n;
    for (int i = 0; i < NW; i++) begin mem[i] = 16'hFFFF; pulses_at[i] = 0; end
    total_pulses = 0; order_err = 0; cur_slow = c.slow; cur_need = c.need;
    cur_cor_en = c.cor_en; cur_cor_addr = c.cor_addr;
    m3 = 0; m4 = 0; m5 = 0; m6 = 0; m10 = 0; fin_cyc = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && !done && !pass, "R2 busy set, result cleared", {busy, done, pass}, 3'b100);
    chk(vcc_hi && vpp_hi, "R2 supplies raised", {vcc_hi, vpp_hi}, 2'b11);
    repeat (100) @(negedge clk);
    start = 1'b1;  // R11: must be ignored
    @(negedge clk) start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done && !busy, "R8/R9 run ends", {done, busy}, 2'b10);
    chk(pass == c.exp_pass, "R9/R8 pass result", pass, c.exp_pass);
    if (!c.exp_pass) chk(fail_addr == c.exp_fail[AW-1:0], "R8/R9 fail_addr", fail_addr, c.exp_fail);
    chk(total_pulses == int'(c.exp_pulses), "R7/R11 pulse count", total_pulses, c.exp_pulses);
    chk(fin_cyc == int'(c.exp_fin_cyc), "R9 nominal-supply reads", fin_cyc, c.exp_fin_cyc);
    chk(m3 == 0, "R3 pulse width", m3, 0);
    chk(m4 == 0, "R4 pulse controls", m4, 0);
    chk(m5 == 0, "R5 setup/hold", m5, 0);
    chk(m6 == 0 && order_err == 0, "R6 blind pass", m6 + order_err, 0);
    chk(m10 == 0, "R10 bus contention", m10, 0);
    chk(!vcc_hi && !vpp_hi && dev_pgm_n, "R8 nominal after end", {vcc_hi, vpp_hi, dev_pgm_n}, 1);
    repeat (10) @(negedge clk);
    chk(done && pass == c.exp_pass && !busy, "R11 result held", {done, pass, busy}, {1'b1, c.exp_pass, 1'b0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_rest("R1 in reset");
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk_rest("R1 idle after reset");
    for (int k = 0; k < NCASE; k++) run_case(CASES[k]);
    // reset in the middle of a pulse
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (60) @(negedge clk);
    chk(!dev_pgm_n, "R3 pulse in progress", dev_pgm_n, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk_rest("R1 mid-run reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_rest("R1 idle after mid-run reset");
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule